// File: doc/BRIEF.md
# Pin Output and Direction Router

This block sits between a set of peripheral functions and one I/O pad. A select value, held in a configuration register outside the block, names one of several function slots. That one value decides which slot's output level reaches the pad. It also decides which slot's drive-enable reaches the pad, so data and direction always come from the same function.

Each slot has a fixed kind, set by a parameter at build time. The kind decides where the slot's direction comes from:
- **GPIO:** the enable comes from a software-written direction register.
- **Bus function:** the function drives its own enable, as an I2C or SD data line does.
- **Output-only:** the driver is always on.
- **Input-only or unconnected:** the driver is never on.

The pad-side outputs are registered together. They are the output level, the output-enable and the input-enable, which is the inverse of the output-enable.

Top module: `pin_out_router`

## Requirements
- R1: While rst_ni is low, pad_out_o is 0, pad_oe_o is 0 and pad_ie_o is 1.
- R2: The outputs change one clock edge after their inputs. The values seen after rising edge k reflect sel_i, fn_out_i and fn_oe_i as sampled at edge k, and out and enable switch on the same edge.
- R3: When sel_i names a GPIO slot, pad_out_o follows that slot's fn_out_i bit and pad_oe_o follows its fn_oe_i bit. Both bits are driven from software registers.
- R4: When sel_i names a bus slot, pad_out_o follows that slot's fn_out_i bit and pad_oe_o follows its fn_oe_i bit, which the function drives.
- R5: When sel_i names an output-only slot, pad_oe_o is 1 and pad_out_o follows the slot's fn_out_i bit. The slot's fn_oe_i bit has no effect.
- R6: When sel_i names an input-only slot, pad_oe_o is 0 and pad_out_o is 0, whatever the slot's inputs are.
- R7: When sel_i names an unconnected slot, pad_oe_o is 0 and pad_out_o is 0, whatever the slot's inputs are.
- R8: pad_ie_o is always the inverse of pad_oe_o.
- R9: Exactly one slot is granted at a time. The inputs of slots that are not selected have no effect on any output.
- R10: The select is SEL_W bits wide (2 by default, 3 for eight slots). Select value n picks slot n, meaning bit n of fn_out_i and of fn_oe_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | SEL_W | Slot select from the pin configuration register |
| fn_out_i | input | 2**SEL_W | Output level of each slot, bit n belongs to slot n |
| fn_oe_i | input | 2**SEL_W | Direction request of each slot (GPIO register or bus function) |
| pad_out_o | output | 1 | Level driven toward the pad |
| pad_oe_o | output | 1 | Pad driver enable |
| pad_ie_o | output | 1 | Pad input enable, inverse of pad_oe_o |

## Verification
The hardest case to reach from the ports is a glitch-free switch. The select moves between slots of different kinds on consecutive cycles while every slot's inputs carry conflicting levels. Only the selected slot may then decide both outputs on the same edge.

The bench builds an eight-slot instance that holds every slot kind. It changes the select on every cycle. It toggles the inputs of unselected slots while one slot stays selected. It drives enable requests into slots whose kind must ignore them.

// File: rtl/pin_mux_pkg.sv
package pin_mux_pkg;
  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_OUT  = 3'd1,
    K_IN   = 3'd2,
    K_GPIO = 3'd3,
    K_BUS  = 3'd4
  } slot_kind_e;
endpackage

// File: rtl/slot_dir_src.sv
module slot_dir_src
  import pin_mux_pkg::*;
#(
  parameter slot_kind_e KIND = K_NONE
) (
  input  logic fn_out_i,
  input  logic fn_oe_i,
  output logic lvl_o,
  output logic en_o
);
  generate
    if (KIND == K_GPIO || KIND == K_BUS) begin : g_owned
      assign lvl_o = fn_out_i;
      assign en_o  = fn_oe_i;
    end else if (KIND == K_OUT) begin : g_out
      assign lvl_o = fn_out_i;
      assign en_o  = 1'b1;
    end else begin : g_off
      // input-only and unconnected slots never drive
      logic unused;
      assign unused = fn_out_i ^ fn_oe_i;
      assign lvl_o  = 1'b0;
      assign en_o   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/slot_decode.sv
module slot_decode #(
  parameter int SEL_W = 2,
  localparam int N = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     grant_o
);
  always_comb begin
    for (int i = 0; i < N; i++) grant_o[i] = (sel_i == SEL_W'(i));
  end

  // R9
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == 1);
endmodule

// File: rtl/and_or_mux.sv
module and_or_mux #(
  parameter int N = 4
) (
  input  logic [N-1:0] grant_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] en_i,
  output logic         lvl_o,
  output logic         en_o
);
  assign lvl_o = |(grant_i & lvl_i);
  assign en_o  = |(grant_i & en_i);
endmodule

// File: rtl/pin_out_router.sv
module pin_out_router
  import pin_mux_pkg::*;
#(
  parameter int SEL_W = 2,
  localparam int N = 1 << SEL_W,
  parameter slot_kind_e [N-1:0] SLOT_KINDS = '{K_NONE, K_OUT, K_BUS, K_GPIO}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N-1:0]     fn_out_i,
  input  logic [N-1:0]     fn_oe_i,
  output logic             pad_out_o,
  output logic             pad_oe_o,
  output logic             pad_ie_o
);
  logic [N-1:0] grant, slot_lvl, slot_en;
  logic         mux_lvl, mux_en;
  logic         out_q, oe_q;

  slot_decode #(.SEL_W(SEL_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .grant_o(grant));

  for (genvar i = 0; i < N; i++) begin : g_slot
    slot_dir_src #(.KIND(SLOT_KINDS[i])) u_src (
      .fn_out_i(fn_out_i[i]), .fn_oe_i(fn_oe_i[i]),
      .lvl_o(slot_lvl[i]), .en_o(slot_en[i]));
  end

  and_or_mux #(.N(N)) u_mux (
    .grant_i(grant), .lvl_i(slot_lvl), .en_i(slot_en),
    .lvl_o(mux_lvl), .en_o(mux_en));

  // level and enable share one register stage: no mixed-slot cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= mux_lvl;
      oe_q  <= mux_en;
    end
  end

  assign pad_out_o = out_q;
  assign pad_oe_o  = oe_q;
  assign pad_ie_o  = ~oe_q;

  slot_kind_e cur_kind;
  assign cur_kind = SLOT_KINDS[sel_i];

  // R5
  out_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_kind == K_OUT |=> pad_oe_o && pad_out_o == $past(fn_out_i[sel_i]));
  // R6
  in_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_kind == K_IN |=> !pad_oe_o && !pad_out_o);
  // R7
  unconn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_kind == K_NONE |=> !pad_oe_o && !pad_out_o);
  // R3 R4
  owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_kind == K_GPIO || cur_kind == K_BUS) |=>
      pad_oe_o == $past(fn_oe_i[sel_i]) && pad_out_o == $past(fn_out_i[sel_i]));
  // R8
  ie_inv_chk: assert property (@(posedge clk_i) pad_ie_o != pad_oe_o);
endmodule

// File: tb/pin_out_router_bench.sv
module pin_out_router_bench;
  import pin_mux_pkg::*;
  localparam int SEL_W = 3;
  localparam int N = 1 << SEL_W;
  localparam slot_kind_e [N-1:0] KINDS =
    '{K_NONE, K_OUT, K_BUS, K_NONE, K_IN, K_OUT, K_BUS, K_GPIO};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [SEL_W-1:0] sel_i = '0;
  logic [N-1:0] fn_out_i = '0, fn_oe_i = '0;
  logic pad_out_o, pad_oe_o, pad_ie_o;

  pin_out_router #(.SEL_W(SEL_W), .SLOT_KINDS(KINDS)) u_pin_out_router (
    .clk_i, .rst_ni, .sel_i, .fn_out_i, .fn_oe_i,
    .pad_out_o, .pad_oe_o, .pad_ie_o);

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic  out;
    logic  oe;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_err = 0;
  bit driving = 0;

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [SEL_W-1:0] s, input logic [N-1:0] fo,
                      input logic [N-1:0] fe, input string tag);
    exp_t e;
    @(negedge clk_i);
    sel_i = s; fn_out_i = fo; fn_oe_i = fe;
    case (KINDS[s])
      K_GPIO, K_BUS: begin e.out = fo[s]; e.oe = fe[s]; end
      K_OUT:         begin e.out = fo[s]; e.oe = 1'b1;  end
      default:       begin e.out = 1'b0;  e.oe = 1'b0;  end
    endcase
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_i); #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(pad_out_o, e.out, e.tag, "pad_out");
        check(pad_oe_o, e.oe, e.tag, "pad_oe");
        check(pad_ie_o, ~e.oe, {e.tag, " R8"}, "pad_ie");
      end
    end
  end

  function automatic string kind_tag(input logic [SEL_W-1:0] s);
    case (KINDS[s])
      K_GPIO:  return "R3";
      K_BUS:   return "R4";
      K_OUT:   return "R5";
      K_IN:    return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin : watchdog
    #200000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin : driver
    // R1 reset state, inputs active
    fn_out_i = '1; fn_oe_i = '1;
    repeat (3) @(posedge clk_i);
    #2;
    check(pad_out_o, 1'b0, "R1", "pad_out");
    check(pad_oe_o, 1'b0, "R1", "pad_oe");
    check(pad_ie_o, 1'b1, "R1", "pad_ie");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 every select value with several patterns
    for (int s = 0; s < N; s++) begin
      step(SEL_W'(s), N'(1 << s), '0, kind_tag(SEL_W'(s)));
      step(SEL_W'(s), N'(1 << s), N'(1 << s), kind_tag(SEL_W'(s)));
      step(SEL_W'(s), ~N'(1 << s), N'(1 << s), kind_tag(SEL_W'(s)));
      step(SEL_W'(s), '1, '1, kind_tag(SEL_W'(s)));
      step(SEL_W'(s), '0, ~N'(1 << s), kind_tag(SEL_W'(s)));
    end

    // R5 enable request ignored on output-only slot
    step(3'd2, 8'h04, 8'h00, "R5");
    step(3'd6, 8'h00, 8'h00, "R5");

    // R9 unselected slots toggle while slot 1 (bus) stays selected
    for (int k = 0; k < 8; k++)
      step(3'd1, (k[0] ? 8'hFD : 8'h00) | {6'd0, k[1], 1'b0},
           (k[0] ? 8'hFD : 8'h02) & {6'h3F, k[2], 1'b1}, "R9");

    // R2 select changes every cycle across kinds
    for (int k = 0; k < 24; k++)
      step(SEL_W'((k * 5) % N), 8'hA5 ^ 8'(k), 8'h3C ^ 8'(k * 3), "R2");

    step(3'd0, 8'h00, 8'h00, "R2");
    repeat (3) @(posedge clk_i);
    #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule